// File: doc/BRIEF.md
# Ethernet MAC Control and Interrupt Register Bank

This block is the register bank of a descriptor-driven Ethernet MAC. It stores the command bits that switch the transmit and receive engines on, the start addresses of the two descriptor lists, a handful of plain configuration words, an interrupt-enable word and an interrupt-status word. A simple word-addressed bus reaches all of it. The word index is the byte address divided by four. A read returns its data one cycle after the request.

The transmit and receive engines report events as one-cycle pulses. Each pulse sets a sticky status bit. Software clears a status bit by writing 1 to it. Status bits in the upper half of the word, masked by their enables, drive the transmit interrupt line. The lower half drives the receive interrupt line.

Setting the software-reset command bit starts a soft reset that runs for a fixed number of cycles. During it every register is held at its reset value, every read returns zero, bus writes are dropped and engine events are lost. The command bit then clears itself. The descriptor list start words can only be rewritten while both engines are off, which in practice means after a soft reset.

Top module: `mac_regfile`

## Requirements
- R1: Writing word 0 with bit 24 set while idle raises `srst_busy` on the next cycle. It stays high for exactly SRST_CYCLES cycles and then falls. Afterwards word 0 reads with bit 24 clear.
- R2: While `srst_busy` is high, every read returns 0 and every bus write is ignored.
- R3: After the hardware reset and after a soft reset completes, the registers read as follows: words 3 and 4 read 0xFFFFFFFC, word 5 reads 0x00000101, word 6 reads 0x00000800, word 7 reads 0x00007FFF, word 8 reads 0x00900000, and every other word reads 0. `tx_en`, `rx_en` and `long_pkt_en` are 0.
- R4: Word 0 stores receive-on in bit 0, long-packet accept in bit 1 and transmit-on in bit 8. These drive `rx_en`, `long_pkt_en` and `tx_en` from the cycle after the write. All other bits of word 0 read 0.
- R5: Word 2 is the interrupt status. Only bits 0, 3, 4, 8, 9, 10, 11, 16, 18, 23 and 24 exist (mask 0x01850F19). A pulse on `rx_evt[i]` sets bit i and a pulse on `tx_evt[i]` sets bit 16+i, visible from the next cycle. Pulses on bits that do not exist have no effect.
- R6: Writing 1 to a bit of word 2 clears it, and writing 0 leaves it unchanged. An event arriving in the same cycle as a clear of the same bit leaves the bit set.
- R7: Word 1 is the interrupt enable, with the same bit set as word 2 (mask 0x01850F19). `tx_irq` is the OR over bits 31..16 of status AND enable. `rx_irq` is the same OR over bits 15..0.
- R8: Words 3 (transmit list) and 4 (receive list) store bits 31..2, and bits 1..0 read 0. A write to them is ignored while `tx_en` or `rx_en` is 1.
- R9: `bus_rdata` updates only on the cycle after `bus_rd` and holds otherwise. Words 9 and 10 are plain 32-bit registers. Words 11 to 15 and all unmapped words read 0.
- R10: Engine events during a soft reset are dropped, and both IRQ lines stay low for the whole reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Byte address; word index is bits ADDR_W-1..2 |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| tx_evt | input | 16 | Transmit event pulses, bit i sets status bit 16+i |
| rx_evt | input | 16 | Receive event pulses, bit i sets status bit i |
| tx_irq | output | 1 | Transmit interrupt |
| rx_irq | output | 1 | Receive interrupt |
| tx_en | output | 1 | Transmit-on command bit |
| rx_en | output | 1 | Receive-on command bit |
| long_pkt_en | output | 1 | Long-packet accept command bit |
| srst_busy | output | 1 | Soft reset in progress |

## Verification
Read data is due one edge after the strobe, so the bench raises `bus_rd` on a falling edge and samples `bus_rdata` on the next falling edge. Status bits, command outputs and the IRQ lines follow an event or write after a single edge, and the bench checks them on the falling edge right after that edge. `srst_busy` rises one edge after the reset write. A monitor counts the falling edges on which it is high and compares the total with SRST_CYCLES. The bench issues a read and a write inside that window, while the blanking still applies.

// File: rtl/mac_regs_pkg.sv
package mac_regs_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned HALF_W = 16;

  // word indices
  localparam int unsigned IX_CTRL   = 0;
  localparam int unsigned IX_IEN    = 1;
  localparam int unsigned IX_ISTAT  = 2;
  localparam int unsigned IX_LIST0  = 3;   // transmit list, receive list follows
  localparam int unsigned NUM_LIST  = 2;
  localparam int unsigned IX_PLAIN0 = IX_LIST0 + NUM_LIST;
  localparam int unsigned NUM_PLAIN = 6;

  // command word bit positions
  localparam int unsigned B_SWR  = 24;
  localparam int unsigned B_TXON = 8;
  localparam int unsigned B_LONG = 1;
  localparam int unsigned B_RXON = 0;

  localparam logic [WORD_W-1:0] ISTAT_MASK = 32'h0185_0F19;
  localparam logic [WORD_W-1:0] LIST_RST   = 32'hFFFF_FFFC;

  typedef struct packed {
    logic tx_on;
    logic rx_on;
    logic long_ok;
  } mac_ctrl_t;

  function automatic logic [WORD_W-1:0] plain_rst(input int unsigned k);
    case (k)
      0:       return 32'h0000_0101;
      1:       return 32'h0000_0800;
      2:       return 32'h0000_7FFF;
      3:       return 32'h0090_0000;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/mac_srst_seq.sv
module mac_srst_seq #(
  parameter int unsigned SRST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(SRST_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = start | busy;
    cnt_d  = start ? LOAD : (cnt_q - CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/mac_int_ctrl.sv
module mac_int_ctrl
  import mac_regs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restore,
  input  logic              ien_we,
  input  logic              ist_we,
  input  logic [WORD_W-1:0] wdata,
  input  logic [HALF_W-1:0] tx_evt,
  input  logic [HALF_W-1:0] rx_evt,
  output logic [WORD_W-1:0] ien_q,
  output logic [WORD_W-1:0] ist_q,
  output logic              tx_irq,
  output logic              rx_irq
);
  logic [WORD_W-1:0] evt_vec;
  assign evt_vec = {tx_evt, rx_evt};

  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    if (ISTAT_MASK[b]) begin : g_live
      logic ien_bit, ien_nxt, ien_en;
      logic ist_bit, ist_nxt, ist_en;

      always_comb begin
        ien_en  = restore | ien_we;
        ien_nxt = restore ? 1'b0 : wdata[b];
        ist_en  = restore | ist_we | evt_vec[b];
        if (restore)                 ist_nxt = 1'b0;
        else if (evt_vec[b])         ist_nxt = 1'b1;
        else if (ist_we && wdata[b]) ist_nxt = 1'b0;
        else                         ist_nxt = ist_bit;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ien_bit <= 1'b0;
        else if (ien_en) ien_bit <= ien_nxt;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ist_bit <= 1'b0;
        else if (ist_en) ist_bit <= ist_nxt;
      end

      assign ien_q[b] = ien_bit;
      assign ist_q[b] = ist_bit;
    end else begin : g_tied
      logic unused_bit;
      assign unused_bit = wdata[b] ^ evt_vec[b];
      assign ien_q[b]   = 1'b0;
      assign ist_q[b]   = 1'b0;
    end
  end

  assign tx_irq = |(ist_q[WORD_W-1:HALF_W] & ien_q[WORD_W-1:HALF_W]);
  assign rx_irq = |(ist_q[HALF_W-1:0] & ien_q[HALF_W-1:0]);
endmodule

// File: rtl/mac_cfg_regs.sv
module mac_cfg_regs
  import mac_regs_pkg::*;
#(
  parameter int unsigned IDX_W = 6
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            restore,
  input  logic                            we,
  input  logic [IDX_W-1:0]                idx,
  input  logic [WORD_W-1:0]               wdata,
  output mac_ctrl_t                       ctrl_q,
  output logic [NUM_LIST-1:0][WORD_W-1:0] list_q,
  output logic [NUM_PLAIN-1:0][WORD_W-1:0] plain_q
);
  // command word
  mac_ctrl_t ctrl_d;
  logic      ctrl_en;

  always_comb begin
    ctrl_en = restore | (we && idx == IDX_W'(IX_CTRL));
    if (restore) ctrl_d = '0;
    else begin
      ctrl_d.tx_on   = wdata[B_TXON];
      ctrl_d.rx_on   = wdata[B_RXON];
      ctrl_d.long_ok = wdata[B_LONG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= '0;
    else if (ctrl_en) ctrl_q <= ctrl_d;
  end

  // descriptor list start words, writable only while both engines are off
  logic list_open;
  assign list_open = !ctrl_q.tx_on && !ctrl_q.rx_on;

  for (genvar j = 0; j < NUM_LIST; j++) begin : g_list
    logic              en;
    logic [WORD_W-1:0] d;
    always_comb begin
      en = restore | (we && list_open && idx == IDX_W'(IX_LIST0 + j));
      d  = restore ? LIST_RST : {wdata[WORD_W-1:2], 2'b00};
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  list_q[j] <= LIST_RST;
      else if (en) list_q[j] <= d;
    end
  end

  // plain configuration words
  for (genvar k = 0; k < NUM_PLAIN; k++) begin : g_plain
    localparam logic [WORD_W-1:0] RV = plain_rst(k);
    logic              en;
    logic [WORD_W-1:0] d;
    always_comb begin
      en = restore | (we && idx == IDX_W'(IX_PLAIN0 + k));
      d  = restore ? RV : wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  plain_q[k] <= RV;
      else if (en) plain_q[k] <= d;
    end
  end
endmodule

// File: rtl/mac_regfile.sv
module mac_regfile
  import mac_regs_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SRST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [15:0]       tx_evt,
  input  logic [15:0]       rx_evt,
  output logic              tx_irq,
  output logic              rx_irq,
  output logic              tx_en,
  output logic              rx_en,
  output logic              long_pkt_en,
  output logic              srst_busy
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  logic [IDX_W-1:0] idx;
  logic [1:0]       unused_addr_lo;
  assign idx            = bus_addr[ADDR_W-1:2];
  assign unused_addr_lo = bus_addr[1:0];

  // soft reset control
  logic srst_start, restore, wr_ok;
  assign srst_start = bus_wr && !srst_busy && idx == IDX_W'(IX_CTRL) && bus_wdata[B_SWR];
  assign restore    = srst_start | srst_busy;
  assign wr_ok      = bus_wr && !restore;

  mac_srst_seq #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst_n (rst_n_int),
    .start (srst_start),
    .busy  (srst_busy)
  );

  mac_ctrl_t                        ctrl_q;
  logic [NUM_LIST-1:0][WORD_W-1:0]  list_q;
  logic [NUM_PLAIN-1:0][WORD_W-1:0] plain_q;

  mac_cfg_regs #(.IDX_W(IDX_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .restore (restore),
    .we      (wr_ok),
    .idx     (idx),
    .wdata   (bus_wdata),
    .ctrl_q  (ctrl_q),
    .list_q  (list_q),
    .plain_q (plain_q)
  );

  logic [WORD_W-1:0] ien_q, ist_q;

  mac_int_ctrl u_int (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .restore (restore),
    .ien_we  (wr_ok && idx == IDX_W'(IX_IEN)),
    .ist_we  (wr_ok && idx == IDX_W'(IX_ISTAT)),
    .wdata   (bus_wdata),
    .tx_evt  (tx_evt),
    .rx_evt  (rx_evt),
    .ien_q   (ien_q),
    .ist_q   (ist_q),
    .tx_irq  (tx_irq),
    .rx_irq  (rx_irq)
  );

  assign tx_en       = ctrl_q.tx_on;
  assign rx_en       = ctrl_q.rx_on;
  assign long_pkt_en = ctrl_q.long_ok;

  // read path
  logic [WORD_W-1:0] rd_mux, rd_nxt;

  always_comb begin
    rd_mux = '0;
    if (idx == IDX_W'(IX_CTRL)) begin
      rd_mux[B_TXON] = ctrl_q.tx_on;
      rd_mux[B_RXON] = ctrl_q.rx_on;
      rd_mux[B_LONG] = ctrl_q.long_ok;
    end
    if (idx == IDX_W'(IX_IEN))   rd_mux = ien_q;
    if (idx == IDX_W'(IX_ISTAT)) rd_mux = ist_q;
    for (int j = 0; j < NUM_LIST; j++)
      if (idx == IDX_W'(IX_LIST0 + j)) rd_mux = list_q[j];
    for (int k = 0; k < NUM_PLAIN; k++)
      if (idx == IDX_W'(IX_PLAIN0 + k)) rd_mux = plain_q[k];
    rd_nxt = srst_busy ? '0 : rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_nxt;
  end
endmodule

// File: rtl/mac_regfile_chk.sv
module mac_regfile_chk #(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SRST_CYCLES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              tx_irq,
  input logic              rx_irq,
  input logic              tx_en,
  input logic              rx_en,
  input logic              srst_busy
);
  localparam int unsigned CNT_W = $clog2(SRST_CYCLES + 2);

  logic [1:0] settle_q;
  logic       ready;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 settle_q <= 2'd0;
    else if (settle_q != 2'd3) settle_q <= settle_q + 2'd1;
  end
  assign ready = (settle_q == 2'd3);

  // consecutive busy cycles seen so far
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_q <= '0;
    else if (srst_busy) run_q <= run_q + CNT_W'(1);
    else                run_q <= '0;
  end

  logic swr_req;
  assign swr_req = ready && bus_wr && !srst_busy &&
                   (bus_addr[ADDR_W-1:2] == '0) && bus_wdata[24];

  logic unused_chk;
  assign unused_chk = ^{bus_addr[1:0], bus_wdata[31:25], bus_wdata[23:0]};

  AST_SRST_START: assert property (@(posedge clk) disable iff (!rst_n)
    swr_req |=> srst_busy);                                           // R1
  AST_SRST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (run_q < SRST_CYCLES));                             // R1
  AST_SRST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_busy) |-> (run_q == SRST_CYCLES));                     // R1
  AST_BLANK_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_busy && bus_rd) |=> (bus_rdata == '0));                     // R2
  AST_ENGINES_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (!tx_en && !rx_en));                                // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));                                  // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    srst_busy |-> (!tx_irq && !rx_irq));                              // R10
endmodule

bind mac_regfile mac_regfile_chk #(
  .ADDR_W      (ADDR_W),
  .SRST_CYCLES (SRST_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .tx_irq    (tx_irq),
  .rx_irq    (rx_irq),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .srst_busy (srst_busy)
);

// File: tb/mac_regfile_test.sv
module mac_regfile_test;
  localparam int AW = 8;
  localparam int SR = 8;
  localparam logic [31:0] SMASK = 32'h0185_0F19;

  logic clk = 1'b0;
  logic rst_n;
  logic [AW-1:0] bus_addr;
  logic bus_wr, bus_rd;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] tx_evt, rx_evt;
  logic tx_irq, rx_irq, tx_en, rx_en, long_pkt_en, srst_busy;

  always #2 clk = ~clk;

  mac_regfile #(.ADDR_W(AW), .SRST_CYCLES(SR)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .tx_evt(tx_evt), .rx_evt(rx_evt), .tx_irq(tx_irq), .rx_irq(rx_irq),
    .tx_en(tx_en), .rx_en(rx_en), .long_pkt_en(long_pkt_en),
    .srst_busy(srst_busy)
  );

  int checks = 0;
  int failures = 0;
  int busy_seen = 0;

  always @(negedge clk) if (srst_busy) busy_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int widx, input logic [31:0] d);
    @(negedge clk);
    bus_addr = AW'(widx * 4); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int widx, output logic [31:0] v);
    @(negedge clk);
    bus_addr = AW'(widx * 4); bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pulse(input bit is_tx, input int b);
    @(negedge clk);
    if (is_tx) tx_evt = 16'(1 << b); else rx_evt = 16'(1 << b);
    @(negedge clk);
    tx_evt = '0; rx_evt = '0;
  endtask

  function automatic logic [31:0] exp_rst(input int i);
    case (i)
      3, 4:    return 32'hFFFF_FFFC;
      5:       return 32'h0000_0101;
      6:       return 32'h0000_0800;
      7:       return 32'h0000_7FFF;
      8:       return 32'h0090_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic sweep(input string phase);
    logic [31:0] v;
    for (int i = 0; i < 64; i++) begin
      rd(i, v);
      chk($sformatf("R3 R9 %s word %0d", phase, i), v, exp_rst(i));
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; tx_evt = '0; rx_evt = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: hardware reset values
    chk("R3 outputs after reset", {28'b0, tx_en, rx_en, long_pkt_en, srst_busy}, 32'h0);
    sweep("hard");

    // R4: command bits
    wr(0, 32'hFEFF_FFFF);
    chk("R4 tx_en/rx_en/long_pkt_en", {29'b0, tx_en, rx_en, long_pkt_en}, 32'h7);
    rd(0, v);
    chk("R4 command readback", v, 32'h0000_0103);

    // R8: list words locked while an engine is on
    wr(3, 32'h1234_5677);
    rd(3, v);
    chk("R8 locked write ignored", v, 32'hFFFF_FFFC);
    wr(0, 32'h0);
    wr(3, 32'h1234_5677);
    rd(3, v);
    chk("R8 list low bits zero", v, 32'h1234_5674);
    wr(4, 32'hABCD_EF03);
    rd(4, v);
    chk("R8 rx list", v, 32'hABCD_EF00);

    // R9: plain words 9 and 10
    wr(9, 32'h5A5A_1234);
    rd(9, v);
    chk("R9 word 9", v, 32'h5A5A_1234);

    // R7: enable mask
    wr(1, 32'hFFFF_FFFF);
    rd(1, v);
    chk("R7 enable mask", v, SMASK);

    // R5 R7 R6: sweep of every event bit
    for (int b = 0; b < 32; b++) begin
      logic [31:0] bitv;
      bit live;
      bitv = 32'h1 << b;
      live = SMASK[b];
      pulse(b >= 16, b % 16);
      chk($sformatf("R7 tx_irq bit %0d", b), {31'b0, tx_irq}, {31'b0, live && b >= 16});
      chk($sformatf("R7 rx_irq bit %0d", b), {31'b0, rx_irq}, {31'b0, live && b < 16});
      rd(2, v);
      chk($sformatf("R5 status bit %0d", b), v, bitv & SMASK);
      wr(2, bitv);
      rd(2, v);
      chk($sformatf("R6 clear bit %0d", b), v, 32'h0);
      chk($sformatf("R7 irq low bit %0d", b), {30'b0, tx_irq, rx_irq}, 32'h0);
    end

    // R6 R7: enable gating, write-0, set priority
    wr(1, 32'h0);
    pulse(1'b0, 4);
    chk("R7 masked rx_irq", {31'b0, rx_irq}, 32'h0);
    wr(2, 32'h0);
    rd(2, v);
    chk("R6 write 0 keeps", v, 32'h10);
    wr(1, 32'h10);
    chk("R7 enabled rx_irq", {30'b0, tx_irq, rx_irq}, 32'h1);
    wr(2, 32'h10);
    @(negedge clk);
    bus_addr = AW'(8); bus_wdata = 32'h10; bus_wr = 1'b1; rx_evt = 16'h0010;
    @(negedge clk);
    bus_wr = 1'b0; rx_evt = '0;
    rd(2, v);
    chk("R6 set beats clear", v, 32'h10);

    // R1 R2 R10: soft reset
    wr(1, 32'hFFFF_FFFF);
    for (int k = 5; k <= 10; k++) wr(k, 32'hC0DE_0000 + 32'(k));
    wr(3, 32'h0000_1000);
    wr(0, 32'h0000_0103);
    pulse(1'b1, 2);
    chk("R7 tx_irq before reset", {31'b0, tx_irq}, 32'h1);
    busy_seen = 0;
    wr(0, 32'h0100_0000);
    chk("R1 busy after start", {31'b0, srst_busy}, 32'h1);
    rd(5, v);
    chk("R2 read blanked", v, 32'h0);
    wr(1, 32'hFFFF_FFFF);
    pulse(1'b0, 0);
    chk("R10 irqs low in reset", {30'b0, tx_irq, rx_irq}, 32'h0);
    while (srst_busy) @(negedge clk);
    chk("R1 busy length", 32'(busy_seen), 32'(SR));
    rd(1, v);
    chk("R2 write during reset ignored", v, 32'h0);
    rd(2, v);
    chk("R10 event during reset dropped", v, 32'h0);
    rd(0, v);
    chk("R1 reset bit self-clears", v, 32'h0);
    sweep("soft");

    summary();
  end
endmodule